// File: doc/BRIEF.md
# AXI4-lite two-target single-outstanding demultiplexer

This block connects one upstream AXI4-lite master port to two downstream AXI4-lite slave ports, such as a register bank and a small memory. The top address bit picks the target. Downstream, each slave sees a local address with that bit cleared. Writes and reads run on separate paths. Each path allows only one transaction in flight, so its channels cannot fall out of step with each other.

A write is taken from the master only when the write address and the write data are both offered in the same cycle. The payload and the chosen target are then captured in registers. From that point the upstream address is not consulted again. Both downstream handshakes, AW and W, must complete, in either order. The write response is then taken from the recorded target only. Reads follow the same scheme on their own path. Everything runs on one clock with an active-low synchronous reset.

Top module: `axil_demux2`

## Requirements
- R1: Address bit ADDR_W-1 equal to 0 routes a transaction to target 0, and equal to 1 routes it to target 1 (SWAP_SEL=0). Vector bit g of every downstream VALID/READY port belongs to target g.
- R2: While only one of s_awvalid and s_wvalid is high, s_awready and s_wready stay low and no downstream write VALID rises.
- R3: s_awready and s_wready are high together for exactly one cycle, the launch cycle. Downstream AWVALID and WVALID of the target rise in the following cycle.
- R4: After a write launch, s_awready stays low until s_bvalid and s_bready have handshaken.
- R5: The write target is latched at launch. Changing s_awaddr afterwards does not redirect the write.
- R6: s_bvalid and s_bresp come only from the latched write target, and m_bready is raised only toward that target.
- R7: The downstream VALID bits of the target not selected stay low at all times.
- R8: Downstream m_awaddr and m_araddr carry the upstream address with bit ADDR_W-1 cleared.
- R9: A downstream VALID, with its address or data, stays high and unchanged until its READY is seen. AW and W may complete in either order.
- R10: Reads accept one request (s_arready) at a time. They latch the target, and return s_rvalid, s_rdata and s_rresp from that target only. No new read is accepted until the R handshake completes.
- R11: While rst_n is low, every VALID and READY output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Upstream write byte strobes |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bresp | output | 2 | Upstream write response code |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_araddr | input | ADDR_W | Upstream read address |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| m_awvalid | output | 2 | Per-target write address valid |
| m_awready | input | 2 | Per-target write address ready |
| m_awaddr | output | ADDR_W | Local write address, shared |
| m_wvalid | output | 2 | Per-target write data valid |
| m_wready | input | 2 | Per-target write data ready |
| m_wdata | output | DATA_W | Write data, shared |
| m_wstrb | output | DATA_W/8 | Write strobes, shared |
| m_bvalid | input | 2 | Per-target write response valid |
| m_bready | output | 2 | Per-target write response ready |
| m_bresp | input | 2x2 | Per-target write response code |
| m_arvalid | output | 2 | Per-target read address valid |
| m_arready | input | 2 | Per-target read address ready |
| m_araddr | output | ADDR_W | Local read address, shared |
| m_rvalid | input | 2 | Per-target read data valid |
| m_rready | output | 2 | Per-target read data ready |
| m_rdata | input | 2xDATA_W | Per-target read data |
| m_rresp | input | 2x2 | Per-target read response code |

## Verification
The assertions rely on the neighbours following the protocol. The master must hold each VALID and its payload until the matching READY. The slaves must raise a response only after both of their request handshakes and hold it until it is taken. The bench master drops its VALIDs only after a handshake, and it perturbs s_awaddr or s_araddr only while the matching VALID is low. The bench slaves derive READY from VALID and a pseudo-random sequence, and they hold B and R until the demultiplexer takes them. Every stimulus therefore stays inside these assumptions, while AW/W ordering and downstream stall lengths are still varied.

// File: rtl/axil_demux_pkg.sv
package axil_demux_pkg;

   localparam int NUM_TGT = 2;
   localparam int RESP_W  = 2;

   typedef enum logic [0:0] {
      TGT_LO = 1'b0,
      TGT_HI = 1'b1
   } tgt_e;

   typedef logic [RESP_W-1:0] resp_t;

endpackage

// File: rtl/axil_demux_route.sv
module axil_demux_route
   import axil_demux_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter bit SWAP_SEL = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output tgt_e              tgt,
   output logic [ADDR_W-1:0] local_addr
);

   localparam int SEL_BIT = ADDR_W - 1;

   generate
      if (SWAP_SEL) begin : g_swap
         assign tgt = addr[SEL_BIT] ? TGT_LO : TGT_HI;
      end else begin : g_direct
         assign tgt = addr[SEL_BIT] ? TGT_HI : TGT_LO;
      end
   endgenerate

   assign local_addr = {1'b0, addr[SEL_BIT-1:0]};

endmodule

// File: rtl/axil_demux_wr.sv
module axil_demux_wr
   import axil_demux_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter bit SWAP_SEL = 1'b0,
   localparam int STRB_W  = DATA_W / 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            s_awvalid,
   output logic                            s_awready,
   input  logic [ADDR_W-1:0]               s_awaddr,
   input  logic                            s_wvalid,
   output logic                            s_wready,
   input  logic [DATA_W-1:0]               s_wdata,
   input  logic [STRB_W-1:0]               s_wstrb,
   output logic                            s_bvalid,
   input  logic                            s_bready,
   output resp_t                           s_bresp,
   output logic [NUM_TGT-1:0]              m_awvalid,
   input  logic [NUM_TGT-1:0]              m_awready,
   output logic [ADDR_W-1:0]               m_awaddr,
   output logic [NUM_TGT-1:0]              m_wvalid,
   input  logic [NUM_TGT-1:0]              m_wready,
   output logic [DATA_W-1:0]               m_wdata,
   output logic [STRB_W-1:0]               m_wstrb,
   input  logic [NUM_TGT-1:0]              m_bvalid,
   output logic [NUM_TGT-1:0]              m_bready,
   input  logic [NUM_TGT-1:0][RESP_W-1:0]  m_bresp
);

   logic              busy_q;
   logic              aw_pend_q;
   logic              w_pend_q;
   tgt_e              tgt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [STRB_W-1:0] strb_q;

   tgt_e              tgt_d;
   logic [ADDR_W-1:0] loc_d;
   logic              launch;
   logic              resp_phase;
   logic              tidx;
   logic              b_done;

   axil_demux_route #(
      .ADDR_W   (ADDR_W),
      .SWAP_SEL (SWAP_SEL)
   ) u_route (
      .addr       (s_awaddr),
      .tgt        (tgt_d),
      .local_addr (loc_d)
   );

   assign tidx       = tgt_q;
   assign launch     = rst_n & ~busy_q & s_awvalid & s_wvalid;
   assign s_awready  = launch;
   assign s_wready   = launch;
   assign resp_phase = rst_n & busy_q & ~aw_pend_q & ~w_pend_q;
   assign s_bvalid   = resp_phase & m_bvalid[tidx];
   assign s_bresp    = m_bresp[tidx];
   assign b_done     = s_bvalid & s_bready;

   assign m_awaddr = addr_q;
   assign m_wdata  = data_q;
   assign m_wstrb  = strb_q;

   for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
      logic hit;
      assign hit          = rst_n & busy_q & (tidx == g[0]);
      assign m_awvalid[g] = hit & aw_pend_q;
      assign m_wvalid[g]  = hit & w_pend_q;
      assign m_bready[g]  = hit & resp_phase & s_bready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         aw_pend_q <= 1'b0;
         w_pend_q  <= 1'b0;
         tgt_q     <= TGT_LO;
      end else begin
         if (launch) begin
            busy_q    <= 1'b1;
            aw_pend_q <= 1'b1;
            w_pend_q  <= 1'b1;
            tgt_q     <= tgt_d;
         end else begin
            if (aw_pend_q && m_awready[tidx]) aw_pend_q <= 1'b0;
            if (w_pend_q && m_wready[tidx])   w_pend_q  <= 1'b0;
            if (b_done)                       busy_q    <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (launch) begin
         addr_q <= loc_d;
         data_q <= s_wdata;
         strb_q <= s_wstrb;
      end
   end

endmodule

// File: rtl/axil_demux_rd.sv
module axil_demux_rd
   import axil_demux_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter bit SWAP_SEL = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            s_arvalid,
   output logic                            s_arready,
   input  logic [ADDR_W-1:0]               s_araddr,
   output logic                            s_rvalid,
   input  logic                            s_rready,
   output logic [DATA_W-1:0]               s_rdata,
   output resp_t                           s_rresp,
   output logic [NUM_TGT-1:0]              m_arvalid,
   input  logic [NUM_TGT-1:0]              m_arready,
   output logic [ADDR_W-1:0]               m_araddr,
   input  logic [NUM_TGT-1:0]              m_rvalid,
   output logic [NUM_TGT-1:0]              m_rready,
   input  logic [NUM_TGT-1:0][DATA_W-1:0]  m_rdata,
   input  logic [NUM_TGT-1:0][RESP_W-1:0]  m_rresp
);

   logic              busy_q;
   logic              ar_pend_q;
   tgt_e              tgt_q;
   logic [ADDR_W-1:0] addr_q;

   tgt_e              tgt_d;
   logic [ADDR_W-1:0] loc_d;
   logic              launch;
   logic              data_phase;
   logic              tidx;

   axil_demux_route #(
      .ADDR_W   (ADDR_W),
      .SWAP_SEL (SWAP_SEL)
   ) u_route (
      .addr       (s_araddr),
      .tgt        (tgt_d),
      .local_addr (loc_d)
   );

   assign tidx       = tgt_q;
   assign launch     = rst_n & ~busy_q & s_arvalid;
   assign s_arready  = launch;
   assign data_phase = rst_n & busy_q & ~ar_pend_q;
   assign s_rvalid   = data_phase & m_rvalid[tidx];
   assign s_rdata    = m_rdata[tidx];
   assign s_rresp    = m_rresp[tidx];
   assign m_araddr   = addr_q;

   for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
      logic hit;
      assign hit          = rst_n & busy_q & (tidx == g[0]);
      assign m_arvalid[g] = hit & ar_pend_q;
      assign m_rready[g]  = hit & data_phase & s_rready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ar_pend_q <= 1'b0;
         tgt_q     <= TGT_LO;
      end else if (launch) begin
         busy_q    <= 1'b1;
         ar_pend_q <= 1'b1;
         tgt_q     <= tgt_d;
      end else begin
         if (ar_pend_q && m_arready[tidx]) ar_pend_q <= 1'b0;
         if (s_rvalid && s_rready)         busy_q    <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (launch) addr_q <= loc_d;
   end

endmodule

// File: rtl/axil_demux2.sv
module axil_demux2
   import axil_demux_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter bit SWAP_SEL = 1'b0,
   localparam int STRB_W  = DATA_W / 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            s_awvalid,
   output logic                            s_awready,
   input  logic [ADDR_W-1:0]               s_awaddr,
   input  logic                            s_wvalid,
   output logic                            s_wready,
   input  logic [DATA_W-1:0]               s_wdata,
   input  logic [STRB_W-1:0]               s_wstrb,
   output logic                            s_bvalid,
   input  logic                            s_bready,
   output logic [1:0]                      s_bresp,
   input  logic                            s_arvalid,
   output logic                            s_arready,
   input  logic [ADDR_W-1:0]               s_araddr,
   output logic                            s_rvalid,
   input  logic                            s_rready,
   output logic [DATA_W-1:0]               s_rdata,
   output logic [1:0]                      s_rresp,
   output logic [1:0]                      m_awvalid,
   input  logic [1:0]                      m_awready,
   output logic [ADDR_W-1:0]               m_awaddr,
   output logic [1:0]                      m_wvalid,
   input  logic [1:0]                      m_wready,
   output logic [DATA_W-1:0]               m_wdata,
   output logic [STRB_W-1:0]               m_wstrb,
   input  logic [1:0]                      m_bvalid,
   output logic [1:0]                      m_bready,
   input  logic [1:0][1:0]                 m_bresp,
   output logic [1:0]                      m_arvalid,
   input  logic [1:0]                      m_arready,
   output logic [ADDR_W-1:0]               m_araddr,
   input  logic [1:0]                      m_rvalid,
   output logic [1:0]                      m_rready,
   input  logic [1:0][DATA_W-1:0]          m_rdata,
   input  logic [1:0][1:0]                 m_rresp
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("axil_demux2: ADDR_W must be at least 2");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("axil_demux2: DATA_W must be a positive multiple of 8");
      end
   endgenerate

   axil_demux_wr #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SWAP_SEL (SWAP_SEL)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_awvalid (s_awvalid),
      .s_awready (s_awready),
      .s_awaddr  (s_awaddr),
      .s_wvalid  (s_wvalid),
      .s_wready  (s_wready),
      .s_wdata   (s_wdata),
      .s_wstrb   (s_wstrb),
      .s_bvalid  (s_bvalid),
      .s_bready  (s_bready),
      .s_bresp   (s_bresp),
      .m_awvalid (m_awvalid),
      .m_awready (m_awready),
      .m_awaddr  (m_awaddr),
      .m_wvalid  (m_wvalid),
      .m_wready  (m_wready),
      .m_wdata   (m_wdata),
      .m_wstrb   (m_wstrb),
      .m_bvalid  (m_bvalid),
      .m_bready  (m_bready),
      .m_bresp   (m_bresp)
   );

   axil_demux_rd #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SWAP_SEL (SWAP_SEL)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_arvalid (s_arvalid),
      .s_arready (s_arready),
      .s_araddr  (s_araddr),
      .s_rvalid  (s_rvalid),
      .s_rready  (s_rready),
      .s_rdata   (s_rdata),
      .s_rresp   (s_rresp),
      .m_arvalid (m_arvalid),
      .m_arready (m_arready),
      .m_araddr  (m_araddr),
      .m_rvalid  (m_rvalid),
      .m_rready  (m_rready),
      .m_rdata   (m_rdata),
      .m_rresp   (m_rresp)
   );

endmodule

// File: rtl/axil_demux2_chk.sv
module axil_demux2_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_awvalid,
   input logic              s_awready,
   input logic              s_wvalid,
   input logic              s_wready,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [1:0]        m_awvalid,
   input logic [1:0]        m_awready,
   input logic [ADDR_W-1:0] m_awaddr,
   input logic [1:0]        m_wvalid,
   input logic [1:0]        m_wready,
   input logic [DATA_W-1:0] m_wdata,
   input logic [1:0]        m_bvalid,
   input logic [1:0]        m_bready,
   input logic [1:0]        m_arvalid,
   input logic [1:0]        m_arready,
   input logic [ADDR_W-1:0] m_araddr,
   input logic [1:0]        m_rvalid,
   input logic [1:0]        m_rready
);

   // R11
   always @(posedge clk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!s_awready && !s_wready && !s_bvalid && !s_arready && !s_rvalid
                                && m_awvalid == 2'b00 && m_wvalid == 2'b00 && m_arvalid == 2'b00
                                && m_bready == 2'b00 && m_rready == 2'b00);
      end
   end

   // R7
   tgt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_awvalid) && $onehot0(m_wvalid) && $onehot0(m_arvalid)
      && $onehot0(m_bready) && $onehot0(m_rready));

   // R7
   aw_w_same_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_awvalid & m_wvalid) != 2'b00) |-> (m_awvalid == m_wvalid));

   // R2
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awready || s_wready) |-> (s_awvalid && s_wvalid));

   // R3
   wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_awready == s_wready);

   // R3
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_awready |=> (!s_awready && m_awvalid != 2'b00 && m_wvalid != 2'b00));

   // R4
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid != 2'b00 || m_wvalid != 2'b00 || s_bvalid) |-> !s_awready);

   // R9
   aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_awvalid & ~m_awready) != 2'b00) |=> ($stable(m_awvalid) && $stable(m_awaddr)));

   // R9
   w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_wvalid & ~m_wready) != 2'b00) |=> ($stable(m_wvalid) && $stable(m_wdata)));

   // R9
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_arvalid & ~m_arready) != 2'b00) |=> ($stable(m_arvalid) && $stable(m_araddr)));

   // R8
   addr_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_awvalid != 2'b00) |-> !m_awaddr[ADDR_W-1]) and ((m_arvalid != 2'b00) |-> !m_araddr[ADDR_W-1]));

   // R6
   b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid |-> (m_bvalid != 2'b00)) and ((m_bready != 2'b00) |-> s_bready));

   // R10
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid != 2'b00 || s_rvalid) |-> !s_arready);

   // R10
   rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid |-> (m_rvalid != 2'b00)) and ((m_rready != 2'b00) |-> s_rready));

   // R10
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_arready |-> s_arvalid);

endmodule

bind axil_demux2 axil_demux2_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/axil_demux2_tb.sv
module axil_demux2_tb;

   localparam int AW = 8;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
   logic [AW-1:0] s_awaddr = 0, s_araddr = 0;
   logic [DW-1:0] s_wdata = 0;
   logic [3:0]    s_wstrb = 4'hF;
   logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]    s_bresp, s_rresp;
   logic [DW-1:0] s_rdata;
   logic [1:0]    m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
   logic [1:0]    m_arvalid, m_arready, m_rvalid, m_rready;
   logic [AW-1:0] m_awaddr, m_araddr;
   logic [DW-1:0] m_wdata;
   logic [3:0]    m_wstrb;
   logic [1:0][1:0]    m_bresp, m_rresp;
   logic [1:0][DW-1:0] m_rdata;

   axil_demux2 #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

   // ---------------- slave models ----------------
   logic [7:0]    lfsr;
   logic          hold_b = 0;
   logic [1:0]    got_aw, got_w, sb_valid, sr_valid;
   logic [4:0]    sa_idx [2];
   logic [DW-1:0] sw_data [2];
   logic [DW-1:0] sr_data [2];
   logic [DW-1:0] smem [2][32];

   assign m_awready = m_awvalid & lfsr[1:0];
   assign m_wready  = m_wvalid  & lfsr[3:2];
   assign m_arready = m_arvalid & lfsr[5:4];
   assign m_bvalid  = sb_valid;
   assign m_rvalid  = sr_valid;
   assign m_bresp   = {2'b01, 2'b00};
   assign m_rresp   = {2'b01, 2'b00};
   assign m_rdata   = {sr_data[1], sr_data[0]};

   always @(posedge clk) begin
      if (!rst_n) begin
         lfsr <= 8'h5A; got_aw <= 0; got_w <= 0; sb_valid <= 0; sr_valid <= 0;
      end else begin
         lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         for (int i = 0; i < 2; i++) begin
            if (m_awvalid[i] && m_awready[i]) begin got_aw[i] <= 1'b1; sa_idx[i] <= m_awaddr[6:2]; end
            if (m_wvalid[i] && m_wready[i]) begin got_w[i] <= 1'b1; sw_data[i] <= m_wdata; end
            if (got_aw[i] && got_w[i] && !sb_valid[i] && !hold_b) begin
               smem[i][sa_idx[i]] <= sw_data[i];
               sb_valid[i] <= 1'b1; got_aw[i] <= 1'b0; got_w[i] <= 1'b0;
            end
            if (sb_valid[i] && m_bready[i]) sb_valid[i] <= 1'b0;
            if (m_arvalid[i] && m_arready[i]) begin
               sr_valid[i] <= 1'b1; sr_data[i] <= smem[i][m_araddr[6:2]];
            end else if (sr_valid[i] && m_rready[i]) sr_valid[i] <= 1'b0;
         end
      end
   end

   // ---------------- monitors ----------------
   int aw_hs [2], ar_hs [2], vld_cyc [2];
   int stab_err = 0;
   logic [AW-1:0] last_awaddr, last_araddr;
   logic [1:0]    p_aw_stall, p_w_stall, p_awvalid, p_wvalid;
   logic [AW-1:0] p_awaddr;
   logic [DW-1:0] p_wdata;

   initial begin
      for (int i = 0; i < 2; i++) begin aw_hs[i] = 0; ar_hs[i] = 0; vld_cyc[i] = 0; end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 2; i++) begin
            if (m_awvalid[i] && m_awready[i]) begin aw_hs[i]++; last_awaddr <= m_awaddr; end
            if (m_arvalid[i] && m_arready[i]) begin ar_hs[i]++; last_araddr <= m_araddr; end
            if (m_awvalid[i] || m_wvalid[i] || m_arvalid[i]) vld_cyc[i]++;
         end
         if (p_aw_stall != 0 && (m_awvalid != p_awvalid || m_awaddr != p_awaddr)) stab_err++;
         if (p_w_stall != 0 && (m_wvalid != p_wvalid || m_wdata != p_wdata)) stab_err++;
         p_aw_stall <= m_awvalid & ~m_awready;
         p_w_stall  <= m_wvalid & ~m_wready;
      end else begin
         p_aw_stall <= 0; p_w_stall <= 0;
      end
      p_awvalid <= m_awvalid; p_awaddr <= m_awaddr;
      p_wvalid  <= m_wvalid;  p_wdata  <= m_wdata;
   end

   // ---------------- checking ----------------
   int checks = 0;
   int errors = 0;
   logic [DW-1:0] expm [64];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   int wd_cnt = 0;
   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd_cnt, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int pass);
      return ({24'h0, a} * 32'h01030507) ^ (32'hA5C30000 + pass);
   endfunction

   // order: 0 together, 1 address first, 2 data first
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int order);
      int t, o, aw0, v0;
      bit lone_bad;
      t = int'(a[AW-1]); o = 1 - t;
      aw0 = aw_hs[t]; v0 = vld_cyc[o];
      lone_bad = 0;
      @(negedge clk);
      if (order == 1) begin s_awvalid = 1; s_awaddr = a; end
      if (order == 2) begin s_wvalid = 1; s_wdata = d; end
      if (order != 0) begin
         repeat (3) begin
            @(negedge clk);
            if (s_awready || s_wready || m_awvalid != 0 || m_wvalid != 0) lone_bad = 1;
         end
         chk(!lone_bad, "R2", "lone valid accepted", 64'(lone_bad), 0);
      end
      s_awvalid = 1; s_awaddr = a; s_wvalid = 1; s_wdata = d;
      #1;
      while (!s_awready) begin @(negedge clk); #1; end
      chk(s_wready, "R3", "wready with awready", 64'(s_wready), 1);
      @(posedge clk);
      @(negedge clk);
      // R3: valids still held, readies must have dropped after one cycle
      chk(!s_awready && !s_wready, "R3", "ready pulse length", {s_awready, s_wready}, 0);
      s_awvalid = 0; s_wvalid = 0;
      s_awaddr = a ^ 8'h80;  // R5: perturb address after launch
      s_bready = 1;
      #1;
      while (!s_bvalid) begin @(negedge clk); #1; end
      chk(s_bresp == 2'(t), "R6", "bresp source", s_bresp, t);
      @(posedge clk);
      @(negedge clk);
      s_bready = 0;
      chk(aw_hs[t] - aw0 == 1, "R1", "write target handshake", aw_hs[t] - aw0, 1);
      chk(vld_cyc[o] == v0, "R7", "other target valid cycles", vld_cyc[o] - v0, 0);
      chk(last_awaddr == (a & 8'h7F), "R8", "local write address", last_awaddr, a & 8'h7F);
      expm[a[7:2]] = d;
   endtask

   task automatic rd(input logic [AW-1:0] a);
      int t, o, ar0, v0;
      t = int'(a[AW-1]); o = 1 - t;
      ar0 = ar_hs[t]; v0 = vld_cyc[o];
      @(negedge clk);
      s_arvalid = 1; s_araddr = a;
      #1;
      while (!s_arready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      chk(!s_arready, "R10", "arready while read outstanding", 64'(s_arready), 0);
      s_arvalid = 0; s_araddr = a ^ 8'h80;
      s_rready = 1;
      #1;
      while (!s_rvalid) begin @(negedge clk); #1; end
      chk(s_rdata == expm[a[7:2]], "R10", "read data", s_rdata, expm[a[7:2]]);
      chk(s_rresp == 2'(t), "R10", "rresp source", s_rresp, t);
      @(posedge clk);
      @(negedge clk);
      s_rready = 0;
      chk(ar_hs[t] - ar0 == 1, "R1", "read target handshake", ar_hs[t] - ar0, 1);
      chk(vld_cyc[o] == v0, "R7", "other target valid during read", vld_cyc[o] - v0, 0);
      chk(last_araddr == (a & 8'h7F), "R8", "local read address", last_araddr, a & 8'h7F);
   endtask

   initial begin
      // R11: reset holds everything quiet even with upstream requests offered
      s_awvalid = 1; s_wvalid = 1; s_arvalid = 1;
      repeat (3) @(negedge clk);
      chk(!s_awready && !s_wready && !s_arready && !s_bvalid && !s_rvalid,
          "R11", "upstream outputs in reset", {s_awready, s_wready, s_arready, s_bvalid, s_rvalid}, 0);
      chk(m_awvalid == 0 && m_wvalid == 0 && m_arvalid == 0 && m_bready == 0 && m_rready == 0,
          "R11", "downstream outputs in reset", {m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
      s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
      rst_n = 1;
      repeat (2) @(negedge clk);

      // sweep every word of both halves, cycling the AW/W arrival order
      for (int k = 0; k < 64; k++) wr(8'(k * 4), pat(8'(k * 4), 0), k % 3);
      for (int k = 0; k < 64; k++) rd(8'(k * 4));

      // R4: one write outstanding; a second request waits for the B handshake
      begin
         bit early;
         hold_b = 1;
         @(negedge clk);
         s_awvalid = 1; s_wvalid = 1; s_awaddr = 8'h04; s_wdata = 32'h1111_2222;
         #1;
         while (!s_awready) begin @(negedge clk); #1; end
         @(posedge clk);
         @(negedge clk);
         s_awaddr = 8'h88; s_wdata = 32'h3333_4444;
         s_bready = 1;
         early = 0;
         repeat (12) begin
            @(negedge clk);
            if (s_awready || s_bvalid) early = 1;
         end
         chk(!early, "R4", "second write accepted before response", 64'(early), 0);
         hold_b = 0;
         #1;
         while (!s_bvalid) begin @(negedge clk); #1; end
         chk(s_bresp == 2'b00, "R6", "first response from target 0", s_bresp, 0);
         @(posedge clk);
         #1;
         while (!s_awready) begin @(negedge clk); #1; end
         @(posedge clk);
         @(negedge clk);
         s_awvalid = 0; s_wvalid = 0;
         #1;
         while (!s_bvalid) begin @(negedge clk); #1; end
         chk(s_bresp == 2'b01, "R4", "queued write reached target 1", s_bresp, 1);
         @(posedge clk);
         @(negedge clk);
         s_bready = 0;
         expm[1] = 32'h1111_2222;
         expm[8'h88 >> 2] = 32'h3333_4444;
      end

      // second pass with new data, reversed order, then read back
      for (int k = 63; k >= 0; k--) wr(8'(k * 4), pat(8'(k * 4), 7), (k + 1) % 3);
      for (int k = 0; k < 64; k++) rd(8'(k * 4));

      chk(stab_err == 0, "R9", "downstream valid/payload stability", stab_err, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule